// File: doc/BRIEF.md
# Oversampled UART Receiver with Sync-Break Capture

This block receives asynchronous serial characters. A tick at sixteen times the bit rate drives it, and it builds 8-bit characters from the line. Parity can be checked on each character. The last good or errored character is held in a one-entry output register with valid/ready semantics. Parity, framing and overrun conditions are kept in a sticky status vector.

A one-shot arm command switches the receiver into sync-break capture. In this mode it ignores characters and waits for the line to stay low for a long period and then return high. It raises the receive-complete pulse when that happens, and the arm command clears itself.

Back-pressure works as follows:
- `rd_valid` stays high until a cycle with `rd_ready` high consumes the character.
- A character that completes while the output register is still full is discarded and reported as an overrun.
- `rd_ready` also serves as the data-read strobe in the error-clear sequence, so it may be pulsed when `rd_valid` is low.
- A `rd_ready` in the same cycle as a character completes is not acted on.

Top module: `uart_brk_rx`

## Requirements
- R1: A low level starts a frame only if it is still low at the mid-point of the start bit, which is 8 ticks after detection. A low pulse shorter than half a bit produces no character and no interrupt.
- R2: Eight data bits are each sampled at mid-bit. With `msb_first`=0 the first received bit lands in `rd_data[0]`. With `msb_first`=1 the first received bit lands in `rd_data[7]`.
- R3: The parity setting `par_mode` takes these values: 0 or 3 means no parity bit, 1 means even parity and 2 means odd parity. Even parity means the ones count of data plus parity is even. Odd parity means that count is odd. A mismatch sets `st_flags[0]`.
- R4: Only one stop bit is checked. A low stop-bit sample sets `st_flags[1]`. A new start bit may follow a single stop bit directly, and both characters are received.
- R5: With `rx_invert`=1 the line is inverted before any sampling, so an idle-low inverted line carries the same characters.
- R6: A completed character sets `rd_valid` with the data in `rd_data`. It raises a one-cycle `irq_rx` pulse if error-free, or a one-cycle `irq_err` pulse if it carries a parity or framing error. The two pulses are never high together. `rd_valid` stays high until a cycle with `rd_ready` high.
- R7: Once set, the error flags stay set until a pulse on `st_rd` is followed by a pulse on `rd_ready`. A `rd_ready` pulse with no preceding `st_rd` leaves the flags unchanged.
- R8: A character that completes while `rd_valid` is high, or while any error flag is set, is discarded. It sets `st_flags[2]` (overrun) and pulses `irq_err`.
- R9: A `brk_arm` pulse arms break capture. While armed, characters are not received. A low level of at least 11 bit-times followed by a high level pulses `irq_rx` once with no character stored. The arm then clears itself, and the next character is received normally.
- R10: A `brk_arm` pulse while a frame is in progress is ignored. A following long low is then received as an errored character and not as a break.
- R11: Reception and arming require both `pwr_on`=1 and `rx_en`=1. With `pwr_on`=0 the receiver, the held character, the arm and all flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial line |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| pwr_on | input | 1 | Unit power; 0 clears everything |
| rx_en | input | 1 | Receive enable, effective only while powered |
| msb_first | input | 1 | 1 = first data bit is the MSB |
| rx_invert | input | 1 | 1 = invert the line before sampling |
| par_mode | input | 2 | 0/3 none, 1 even, 2 odd |
| brk_arm | input | 1 | One-cycle arm command for break capture |
| rd_data | output | 8 | Held character |
| rd_valid | output | 1 | A character is held |
| rd_ready | input | 1 | Consume character / data-read strobe |
| st_rd | input | 1 | Status-read strobe |
| st_flags | output | 3 | bit0 parity, bit1 framing, bit2 overrun |
| irq_rx | output | 1 | Character or break received |
| irq_err | output | 1 | Errored or discarded character |

## Verification
Several properties are checked on every cycle:
- the two interrupt pulses never coincide;
- an error pulse always comes with a set flag;
- flags persist whenever no data-read strobe occurs;
- a held character stays valid under back-pressure;
- power-off empties the buffer, flags and arm;
- an arm command issued mid-frame never takes.

Only the directed scenarios can show the following:
- sampling points and glitch rejection;
- bit order, parity arithmetic and inversion;
- the ordered status-then-data clear sequence;
- that a long low is treated as a break only when armed;
- that the arm is gone after one break.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_OFF  = 2'd3
  } par_t;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_START,
    FR_DATA,
    FR_PAR,
    FR_STOP
  } fr_state_t;

  localparam int FLAG_PAR = 0;
  localparam int FLAG_FRM = 1;
  localparam int FLAG_OVR = 2;
  localparam int NFLAGS   = 3;
endpackage

// File: rtl/rx_front.sv
module rx_front #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  input  logic invert,
  output logic rx_s
);
  logic [SYNC-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[SYNC-2:0], rx_in ^ invert};
  end

  assign rx_s = sh[SYNC-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          rxd,
  input  logic          msb_first,
  input  logic [1:0]    par_mode,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] d_out,
  output logic          perr,
  output logic          ferr
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW);
  localparam logic [CW-1:0] HALF_M1 = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(OSR - 1);
  localparam logic [BW-1:0] NB_LAST = BW'(DW - 1);

  fr_state_t     state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] nbit;
  logic [DW-1:0] sh;
  logic          par_acc;
  logic          samp;
  logic          par_on;

  assign samp   = (state == FR_START) ? (cnt == HALF_M1) : (cnt == FULL_M1);
  assign par_on = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
  assign busy   = (state != FR_IDLE);
  assign d_out  = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= FR_IDLE;
      cnt     <= '0;
      nbit    <= '0;
      sh      <= '0;
      par_acc <= 1'b0;
      perr    <= 1'b0;
      ferr    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        state <= FR_IDLE;
        cnt   <= '0;
      end else if (tick) begin
        if (state != FR_IDLE && !samp) cnt <= cnt + 1'b1;
        else                           cnt <= '0;
        case (state)
          FR_IDLE: if (!rxd) state <= FR_START;
          FR_START: if (samp) begin
            if (!rxd) begin
              state   <= FR_DATA;
              nbit    <= '0;
              par_acc <= 1'b0;
              perr    <= 1'b0;
            end else begin
              state <= FR_IDLE;
            end
          end
          FR_DATA: if (samp) begin
            sh      <= msb_first ? {sh[DW-2:0], rxd} : {rxd, sh[DW-1:1]};
            par_acc <= par_acc ^ rxd;
            nbit    <= nbit + 1'b1;
            if (nbit == NB_LAST) state <= par_on ? FR_PAR : FR_STOP;
          end
          FR_PAR: if (samp) begin
            perr  <= (par_mode == PAR_ODD) ? ~(par_acc ^ rxd) : (par_acc ^ rxd);
            state <= FR_STOP;
          end
          FR_STOP: if (samp) begin
            ferr  <= ~rxd;
            done  <= 1'b1;
            state <= FR_IDLE;
          end
          default: state <= FR_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_brk.sv
module rx_brk #(
  parameter int OSR      = 16,
  parameter int BRK_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic rxd,
  input  logic arm_req,
  input  logic frame_busy,
  output logic armed,
  output logic brk_done
);
  localparam int LIM = OSR * BRK_BITS;
  localparam int LW  = $clog2(LIM + 1);
  localparam logic [LW-1:0] LIM_V = LW'(LIM);

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      low_cnt  <= '0;
      brk_done <= 1'b0;
    end else begin
      brk_done <= 1'b0;
      if (!en) begin
        armed   <= 1'b0;
        low_cnt <= '0;
      end else if (!armed) begin
        low_cnt <= '0;
        if (arm_req && !frame_busy) armed <= 1'b1;
      end else if (tick) begin
        if (!rxd) begin
          if (low_cnt != LIM_V) low_cnt <= low_cnt + 1'b1;
        end else begin
          if (low_cnt == LIM_V) begin
            brk_done <= 1'b1;
            armed    <= 1'b0;
          end
          low_cnt <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/rx_errbuf.sv
module rx_errbuf
  import uart_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              fr_done,
  input  logic [DW-1:0]     fr_data,
  input  logic              fr_perr,
  input  logic              fr_ferr,
  input  logic              brk_done,
  input  logic              st_rd,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic [NFLAGS-1:0] flags,
  output logic              irq_rx,
  output logic              irq_err
);
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      flags    <= '0;
      seen     <= 1'b0;
      irq_rx   <= 1'b0;
      irq_err  <= 1'b0;
    end else if (!en) begin
      rd_valid <= 1'b0;
      flags    <= '0;
      seen     <= 1'b0;
      irq_rx   <= 1'b0;
      irq_err  <= 1'b0;
    end else begin
      irq_rx  <= brk_done;
      irq_err <= 1'b0;
      if (fr_done) begin
        if (rd_valid || (|flags)) begin
          flags[FLAG_OVR] <= 1'b1;
          irq_err         <= 1'b1;
        end else begin
          rd_data         <= fr_data;
          rd_valid        <= 1'b1;
          flags[FLAG_PAR] <= fr_perr;
          flags[FLAG_FRM] <= fr_ferr;
          if (fr_perr || fr_ferr) irq_err <= 1'b1;
          else                    irq_rx  <= 1'b1;
        end
      end else begin
        if (rd_ready) begin
          rd_valid <= 1'b0;
          if (seen) begin
            flags <= '0;
            seen  <= 1'b0;
          end
        end
        if (st_rd) seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
  import uart_rx_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int DW       = 8,
  parameter int BRK_BITS = 11,
  parameter int SYNC     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in,
  input  logic              os_tick,
  input  logic              pwr_on,
  input  logic              rx_en,
  input  logic              msb_first,
  input  logic              rx_invert,
  input  logic [1:0]        par_mode,
  input  logic              brk_arm,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  input  logic              st_rd,
  output logic [NFLAGS-1:0] st_flags,
  output logic              irq_rx,
  output logic              irq_err
);
  logic          rxd;
  logic          rx_on;
  logic          armed;
  logic          brk_done;
  logic          fr_busy;
  logic          fr_done;
  logic [DW-1:0] fr_data;
  logic          fr_perr;
  logic          fr_ferr;

  assign rx_on = pwr_on & rx_en;

  rx_front #(.SYNC(SYNC)) u_front (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .invert(rx_invert), .rx_s(rxd)
  );

  rx_frame #(.OSR(OSR), .DW(DW)) u_frame (
    .clk(clk), .rst_n(rst_n), .en(rx_on & ~armed), .tick(os_tick), .rxd(rxd),
    .msb_first(msb_first), .par_mode(par_mode), .busy(fr_busy), .done(fr_done),
    .d_out(fr_data), .perr(fr_perr), .ferr(fr_ferr)
  );

  rx_brk #(.OSR(OSR), .BRK_BITS(BRK_BITS)) u_brk (
    .clk(clk), .rst_n(rst_n), .en(rx_on), .tick(os_tick), .rxd(rxd),
    .arm_req(brk_arm), .frame_busy(fr_busy), .armed(armed), .brk_done(brk_done)
  );

  rx_errbuf #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .en(pwr_on), .fr_done(fr_done), .fr_data(fr_data),
    .fr_perr(fr_perr), .fr_ferr(fr_ferr), .brk_done(brk_done), .st_rd(st_rd),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data), .flags(st_flags),
    .irq_rx(irq_rx), .irq_err(irq_err)
  );
endmodule

// File: rtl/uart_brk_rx_chk.sv
module uart_brk_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_on,
  input logic       brk_arm,
  input logic       rd_ready,
  input logic       rd_valid,
  input logic [2:0] st_flags,
  input logic       irq_rx,
  input logic       irq_err,
  input logic       armed,
  input logic       fr_busy
);
  p_irq_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_rx && irq_err));

  p_valid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && rd_valid && !rd_ready) |=> rd_valid);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && (|st_flags) && !rd_ready) |=> (|st_flags));

  p_err_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (|st_flags));

  p_arm_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_arm && fr_busy && !armed) |=> !armed);

  p_pwr_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> (st_flags == 3'b000 && !rd_valid && !armed));
endmodule

bind uart_brk_rx uart_brk_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .brk_arm(brk_arm),
  .rd_ready(rd_ready), .rd_valid(rd_valid), .st_flags(st_flags),
  .irq_rx(irq_rx), .irq_err(irq_err), .armed(armed), .fr_busy(fr_busy)
);

// File: tb/sim_uart_brk_rx.sv
module sim_uart_brk_rx;
  localparam int BITC = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_l = 1'b1;
  logic       inv_b = 1'b0;
  logic       rx_in;
  logic       os_tick = 1'b0;
  logic [1:0] tdiv = 2'd0;
  logic       pwr_on = 1'b0, rx_en = 1'b0, msb_first = 1'b0, rx_invert = 1'b0;
  logic [1:0] par_mode = 2'd0;
  logic       brk_arm = 1'b0, rd_ready = 1'b0, st_rd = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic [2:0] st_flags;
  logic       irq_rx, irq_err;
  int         n_rx = 0, n_err = 0;
  int         checks = 0, errors = 0;

  assign rx_in = line_l ^ inv_b;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tdiv    <= tdiv + 2'd1;
    os_tick <= (tdiv == 2'd3);
    if (irq_rx)  n_rx  <= n_rx + 1;
    if (irq_err) n_err <= n_err + 1;
  end

  uart_brk_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .os_tick(os_tick), .pwr_on(pwr_on),
    .rx_en(rx_en), .msb_first(msb_first), .rx_invert(rx_invert), .par_mode(par_mode),
    .brk_arm(brk_arm), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .st_rd(st_rd), .st_flags(st_flags), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    line_l = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic msb, input logic [1:0] pm,
                            input logic bad_par, input logic stop_low, input int idle_bits);
    hold(1'b0, BITC);
    for (int i = 0; i < 8; i++) hold(msb ? d[7-i] : d[i], BITC);
    if (pm == 2'd1 || pm == 2'd2) hold((^d) ^ (pm == 2'd2) ^ bad_par, BITC);
    if (stop_low) begin
      hold(1'b0, 48);
      hold(1'b1, 16);
    end else begin
      hold(1'b1, BITC);
    end
    hold(1'b1, idle_bits * BITC);
  endtask

  task automatic pulse_rd();
    rd_ready = 1'b1; @(negedge clk); rd_ready = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_st();
    st_rd = 1'b1; @(negedge clk); st_rd = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_arm();
    brk_arm = 1'b1; @(negedge clk); brk_arm = 1'b0; @(negedge clk);
  endtask

  task automatic clear_errs();
    pulse_st();
    pulse_rd();
  endtask

  task automatic t_reset();
    chk("R11 reset rd_valid", rd_valid, 0);
    chk("R11 reset flags", st_flags, 0);
    chk("R6 reset irqs", {irq_rx, irq_err}, 0);
  endtask

  task automatic t_lsb();
    int r0;
    r0 = n_rx;
    send_frame(8'hA5, 1'b0, 2'd0, 1'b0, 1'b0, 2);
    chk("R2 lsb data", rd_data, 8'hA5);
    chk("R6 valid set", rd_valid, 1);
    chk("R6 irq_rx pulse", n_rx - r0, 1);
    chk("R6 no flags", st_flags, 0);
    repeat (20) @(negedge clk);
    chk("R6 valid held", rd_valid, 1);
    pulse_rd();
    chk("R6 consumed", rd_valid, 0);
  endtask

  task automatic t_msb();
    msb_first = 1'b1;
    send_frame(8'h3C, 1'b1, 2'd0, 1'b0, 1'b0, 2);
    chk("R2 msb data", rd_data, 8'h3C);
    pulse_rd();
    msb_first = 1'b0;
  endtask

  task automatic t_parity();
    int e0;
    par_mode = 2'd1;
    send_frame(8'h07, 1'b0, 2'd1, 1'b0, 1'b0, 2);
    chk("R3 even ok data", rd_data, 8'h07);
    chk("R3 even ok flags", st_flags, 0);
    pulse_rd();
    par_mode = 2'd2;
    send_frame(8'h0F, 1'b0, 2'd2, 1'b0, 1'b0, 2);
    chk("R3 odd ok flags", st_flags, 0);
    pulse_rd();
    e0 = n_err;
    send_frame(8'h55, 1'b0, 2'd2, 1'b1, 1'b0, 2);
    chk("R3 odd bad flag", st_flags, 3'b001);
    chk("R6 irq_err on parity", n_err - e0, 1);
    chk("R6 errored data kept", rd_data, 8'h55);
    clear_errs();
    chk("R7 clear seq", st_flags, 0);
    par_mode = 2'd0;
  endtask

  task automatic t_invert();
    inv_b = 1'b1; rx_invert = 1'b1;
    repeat (BITC) @(negedge clk);
    send_frame(8'h5A, 1'b0, 2'd0, 1'b0, 1'b0, 2);
    chk("R5 inverted data", rd_data, 8'h5A);
    chk("R5 inverted flags", st_flags, 0);
    pulse_rd();
    inv_b = 1'b0; rx_invert = 1'b0;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic t_glitch();
    int r0, e0;
    r0 = n_rx; e0 = n_err;
    hold(1'b0, 12);
    hold(1'b1, 12 * BITC);
    chk("R1 glitch no valid", rd_valid, 0);
    chk("R1 glitch no irq", (n_rx - r0) + (n_err - e0), 0);
  endtask

  task automatic t_framing_overrun();
    send_frame(8'hC3, 1'b0, 2'd0, 1'b0, 1'b1, 2);
    chk("R4 framing flag", st_flags, 3'b010);
    pulse_rd();
    chk("R7 data read alone keeps flags", st_flags, 3'b010);
    send_frame(8'h12, 1'b0, 2'd0, 1'b0, 1'b0, 2);
    chk("R8 overrun on pending error", st_flags, 3'b110);
    chk("R8 discarded", rd_valid, 0);
    clear_errs();
    chk("R7 cleared", st_flags, 0);
    send_frame(8'h44, 1'b0, 2'd0, 1'b0, 1'b0, 2);
    send_frame(8'h99, 1'b0, 2'd0, 1'b0, 1'b0, 2);
    chk("R8 overrun on full buffer", st_flags, 3'b100);
    chk("R8 first data kept", rd_data, 8'h44);
    clear_errs();
  endtask

  task automatic t_back_to_back();
    logic [7:0] g1, g2;
    g1 = 8'h00; g2 = 8'h00;
    fork
      begin
        send_frame(8'h11, 1'b0, 2'd0, 1'b0, 1'b0, 0);
        send_frame(8'h22, 1'b0, 2'd0, 1'b0, 1'b0, 2);
      end
      begin
        while (!rd_valid) @(negedge clk);
        g1 = rd_data; pulse_rd();
        while (!rd_valid) @(negedge clk);
        g2 = rd_data; pulse_rd();
      end
    join
    chk("R4 one stop first", g1, 8'h11);
    chk("R4 one stop second", g2, 8'h22);
    chk("R4 no flags", st_flags, 0);
  endtask

  task automatic t_break();
    int r0;
    pulse_arm();
    r0 = n_rx;
    hold(1'b0, 13 * BITC);
    hold(1'b1, 3 * BITC);
    chk("R9 break irq", n_rx - r0, 1);
    chk("R9 no data", rd_valid, 0);
    chk("R9 no flags", st_flags, 0);
    send_frame(8'h81, 1'b0, 2'd0, 1'b0, 1'b0, 2);
    chk("R9 arm self-cleared", rd_valid, 1);
    chk("R9 next data", rd_data, 8'h81);
    pulse_rd();
  endtask

  task automatic t_arm_busy();
    int r0;
    fork
      send_frame(8'h96, 1'b0, 2'd0, 1'b0, 1'b0, 2);
      begin repeat (3 * BITC) @(negedge clk); pulse_arm(); end
    join
    chk("R10 frame still received", rd_data, 8'h96);
    pulse_rd();
    r0 = n_rx;
    hold(1'b0, 13 * BITC);
    hold(1'b1, 10 * BITC);
    chk("R10 no break irq", n_rx - r0, 0);
    chk("R10 framing seen", st_flags[1], 1);
    pwr_on = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 power off flags", st_flags, 0);
    chk("R11 power off valid", rd_valid, 0);
    pwr_on = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_enable();
    int r0;
    r0 = n_rx;
    pwr_on = 1'b0;
    send_frame(8'h3A, 1'b0, 2'd0, 1'b0, 1'b0, 2);
    chk("R11 unpowered ignores", rd_valid, 0);
    pwr_on = 1'b1; rx_en = 1'b0;
    send_frame(8'h3A, 1'b0, 2'd0, 1'b0, 1'b0, 2);
    chk("R11 disabled ignores", rd_valid, 0);
    chk("R11 no irq", n_rx - r0, 0);
    rx_en = 1'b1;
    send_frame(8'h3A, 1'b0, 2'd0, 1'b0, 1'b0, 2);
    chk("R11 enabled receives", rd_data, 8'h3A);
    pulse_rd();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    pwr_on = 1'b1; rx_en = 1'b1;
    repeat (BITC) @(negedge clk);
    t_lsb();
    t_msb();
    t_parity();
    t_invert();
    t_glitch();
    t_framing_overrun();
    t_back_to_back();
    t_break();
    t_arm_busy();
    t_enable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule